// File: doc/BRIEF.md
# Dynamic Bus Sizing Master Controller

This block sequences bus cycles for a master that moves byte, word or long-word operands over a 16-bit external data bus. The slave does not have to be as wide as the bus. On every cycle it reports its port width through two acknowledge inputs. The master then works out how many bytes that cycle moved and whether more cycles are needed.

A request carries the operand size, an aligned address and, for writes, right-justified write data. The controller then starts a cycle and holds the address, size code and strobe until an acknowledge arrives. After a partial acknowledge it advances the address and reduces the remaining count, leaves one idle clock, and starts the next cycle. Read bytes are shifted into a 32-bit assembly register with the most significant byte first. The operand comes out right-justified together with a one-cycle done pulse.

A request with a misaligned word or long-word address, or with the three-byte size code, is refused. It raises a one-cycle error pulse and no bus cycle is started.

Top module: `dbs_master`

## Requirements
- R1: After reset, req_ready is 1 and bus_strobe, done and req_err are 0.
- R2: A request whose size is word (10) or long word (00) with req_addr[0]=1, or whose size code is 11, raises req_err for exactly one cycle on the next clock. It starts no bus cycle (bus_strobe stays 0), and req_ready stays 1.
- R3: bus_siz carries the number of bytes still to be moved, coded 01=one, 10=two, 11=three, 00=four. The first cycle of an operand therefore shows the requested size, and bus_addr equals req_addr.
- R4: While bus_strobe is 1 and neither acknowledge is asserted, bus_strobe, bus_addr, bus_siz, bus_write and bus_wdata hold their values, so any number of wait states is tolerated.
- R5: ack_word (with or without ack_byte) marks a 16-bit port, and ack_byte alone marks an 8-bit port. An 8-bit port moves one byte per cycle. A 16-bit port moves two bytes when the address is even and two or more remain; otherwise it moves one.
- R6: After an acknowledge that leaves bytes remaining, bus_strobe is 0 for exactly one clock. The next cycle's address is the previous one plus the bytes moved.
- R7: On writes, bus_wdata[15:8] carries the most significant remaining byte. bus_wdata[7:0] carries the next one, or repeats the same byte when only one remains.
- R8: On reads, an 8-bit port's byte is taken from bits 15:8. A 16-bit port's two bytes come from 15:8 then 7:0. A 16-bit port's single byte comes from 15:8 at an even address and from 7:0 at an odd address.
- R9: done pulses for one cycle on the clock after the final acknowledge. During that cycle rdata holds the read operand right-justified, with byte 0 (the lowest address) as its most significant byte.
- R10: The cycle count per operand is: long word to 8-bit port, 4; long word to 16-bit port, 2; word to 8-bit port, 2; word to 16-bit port, 1; byte, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_siz | input | 2 | Operand size: 01 byte, 10 word, 00 long word |
| req_addr | input | ADDR_W | Operand start address |
| req_wdata | input | 32 | Write operand, right-justified |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_err | output | 1 | One-cycle pulse: request refused |
| bus_strobe | output | 1 | Bus cycle active |
| bus_write | output | 1 | Direction of the active cycle |
| bus_addr | output | ADDR_W | Cycle address |
| bus_siz | output | 2 | Bytes remaining, coded as in R3 |
| bus_wdata | output | 16 | Write data lanes |
| bus_rdata | input | 16 | Read data lanes |
| ack_byte | input | 1 | Acknowledge from an 8-bit port |
| ack_word | input | 1 | Acknowledge from a 16-bit port |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read operand, right-justified |

## Verification
A wrong remaining count shows up on bus_siz from the very next cycle. It then changes the number of cycles and the moment done appears. An address step error appears on bus_addr in the first cycle after the one-clock gap. A lane-steering or shift mistake in the write path is visible on bus_wdata during the cycle it affects. A read assembly mistake stays hidden until done, when the whole operand is compared against the bytes the slave model served.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int OP_W   = 32;
  localparam int BUS_W  = 16;
  localparam int OP_BY  = OP_W / 8;
  localparam int CNT_W  = $clog2(OP_BY + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} dbs_state_e;

  // size code -> byte count (00 means four)
  function automatic logic [CNT_W-1:0] code_to_bytes(input logic [1:0] code);
    return (code == 2'b00) ? CNT_W'(OP_BY) : CNT_W'(code);
  endfunction

  // remaining byte count -> size code
  function automatic logic [1:0] bytes_to_code(input logic [CNT_W-1:0] n);
    return n[1:0];
  endfunction

  // bytes moved by one acknowledged cycle
  function automatic logic [CNT_W-1:0] moved(input logic wide, input logic odd,
                                              input logic [CNT_W-1:0] rem);
    return (wide && !odd && rem >= CNT_W'(2)) ? CNT_W'(2) : CNT_W'(1);
  endfunction

  // request legality: bytes anywhere, word/long even, three-byte never
  function automatic logic req_legal(input logic [1:0] code, input logic a0);
    return (code == 2'b01) || ((code != 2'b11) && !a0);
  endfunction
endpackage

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic reject,
  input  logic acked,
  input  logic last,
  output logic strobe,
  output logic ready,
  output logic done,
  output logic err
);
  dbs_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start)  state <= ST_RUN;
          if (reject) err   <= 1'b1;
        end
        ST_RUN: begin
          if (acked) begin
            if (last) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_GAP;
            end
          end
        end
        ST_GAP:  state <= ST_RUN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe = (state == ST_RUN);
  assign ready  = (state == ST_IDLE);
endmodule

// File: rtl/dbs_track.sv
module dbs_track
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_siz,
  input  logic              req_write,
  input  logic              acked,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  rem,
  output logic              wr,
  output logic [CNT_W-1:0]  n_move,
  output logic              last
);
  assign n_move = moved(wide, addr[0], rem);
  assign last   = (rem <= n_move);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      rem  <= '0;
      wr   <= 1'b0;
    end else if (start) begin
      addr <= req_addr;
      rem  <= code_to_bytes(req_siz);
      wr   <= req_write;
    end else if (acked) begin
      addr <= addr + ADDR_W'(n_move);
      rem  <= rem - n_move;
    end
  end
endmodule

// File: rtl/dbs_rd_assemble.sv
module dbs_rd_assemble
  import dbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             acked,
  input  logic [CNT_W-1:0] n_move,
  input  logic             low_lane,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic [OP_W-1:0]  asm_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0;
    end else if (start) begin
      asm_q <= '0;
    end else if (acked) begin
      if (n_move == CNT_W'(2))
        asm_q <= {asm_q[OP_W-BUS_W-1:0], bus_rdata};
      else if (low_lane)
        asm_q <= {asm_q[OP_W-9:0], bus_rdata[7:0]};
      else
        asm_q <= {asm_q[OP_W-9:0], bus_rdata[15:8]};
    end
  end
endmodule

// File: rtl/dbs_wr_steer.sv
module dbs_wr_steer
  import dbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       req_siz,
  input  logic [OP_W-1:0]  req_wdata,
  input  logic             acked,
  input  logic [CNT_W-1:0] n_move,
  input  logic [CNT_W-1:0] rem,
  output logic [BUS_W-1:0] bus_wdata
);
  logic [OP_W-1:0] sh_q;
  logic [CNT_W-1:0] load_bytes;

  assign load_bytes = code_to_bytes(req_siz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (start) begin
      sh_q <= req_wdata << (8 * (OP_BY - int'(load_bytes)));
    end else if (acked) begin
      sh_q <= (n_move == CNT_W'(2)) ? (sh_q << 16) : (sh_q << 8);
    end
  end

  assign bus_wdata = (rem == CNT_W'(1)) ? {sh_q[OP_W-1 -: 8], sh_q[OP_W-1 -: 8]}
                                        : sh_q[OP_W-1 -: BUS_W];
endmodule

// File: rtl/dbs_master.sv
module dbs_master
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_siz,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              req_err,
  output logic              bus_strobe,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  input  logic              ack_byte,
  input  logic              ack_word,
  output logic              done,
  output logic [31:0]       rdata
);
  // named internal events
  logic             take;
  logic             start_ok;
  logic             reject;
  logic             acked;
  logic             last_xfer;
  logic             low_lane;
  logic [CNT_W-1:0] n_move;
  logic [CNT_W-1:0] rem;

  assign take     = req_valid && req_ready;
  assign start_ok = take && req_legal(req_siz, req_addr[0]);
  assign reject   = take && !req_legal(req_siz, req_addr[0]);
  assign acked    = bus_strobe && (ack_byte || ack_word);
  assign low_lane = ack_word && bus_addr[0];

  dbs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .reject(reject),
    .acked(acked), .last(last_xfer), .strobe(bus_strobe),
    .ready(req_ready), .done(done), .err(req_err)
  );

  dbs_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .req_addr(req_addr),
    .req_siz(req_siz), .req_write(req_write), .acked(acked),
    .wide(ack_word), .addr(bus_addr), .rem(rem), .wr(bus_write),
    .n_move(n_move), .last(last_xfer)
  );

  dbs_rd_assemble u_rd (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .acked(acked),
    .n_move(n_move), .low_lane(low_lane), .bus_rdata(bus_rdata),
    .asm_q(rdata)
  );

  dbs_wr_steer u_wr (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .req_siz(req_siz),
    .req_wdata(req_wdata), .acked(acked), .n_move(n_move), .rem(rem),
    .bus_wdata(bus_wdata)
  );

  assign bus_siz = bytes_to_code(rem);
endmodule

// File: rtl/dbs_master_chk.sv
module dbs_master_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_err,
  input logic              reject,
  input logic              bus_strobe,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz,
  input logic [15:0]       bus_wdata,
  input logic              done,
  input logic              acked,
  input logic              last_xfer,
  input logic [2:0]        n_move
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_strobe);

  assert_reject_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (req_err && !bus_strobe));

  assert_err_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> !req_err);

  assert_hold_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !acked) |=> (bus_strobe && $stable(bus_addr) &&
                                $stable(bus_siz) && $stable(bus_wdata)));

  assert_gap_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acked && !last_xfer) |=> !bus_strobe);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acked && !last_xfer) |=> (bus_addr == $past(bus_addr) + ADDR_W'($past(n_move))));

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acked && last_xfer) |=> (done && !bus_strobe));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_not_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, req_err}));
endmodule

bind dbs_master dbs_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
  .reject(reject), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
  .bus_siz(bus_siz), .bus_wdata(bus_wdata), .done(done), .acked(acked),
  .last_xfer(last_xfer), .n_move(n_move)
);

// File: tb/test_dbs_master.sv
`timescale 1ns/1ps
module test_dbs_master;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_siz = 2'b01;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, req_err, bus_strobe, bus_write, done;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata = '0;
  logic          ack_byte = 1'b0;
  logic          ack_word = 1'b0;
  logic [31:0]   rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dbs_master #(.ADDR_W(AW)) i_dbs_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_siz(req_siz), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_err(req_err), .bus_strobe(bus_strobe),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_siz(bus_siz),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_byte(ack_byte),
    .ack_word(ack_word), .done(done), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // slave memory contents
  function automatic logic [7:0] mem_b(input logic [AW-1:0] a);
    return (a[7:0] * 8'd13) ^ 8'h5A ^ a[15:8];
  endfunction

  function automatic int bytes_of(input logic [1:0] s);
    return (s == 2'b00) ? 4 : int'(s);
  endfunction

  function automatic logic [1:0] code_of(input int n);
    return 2'(n % 4);
  endfunction

  // operand byte k (0 = most significant) of an n-byte right-justified value
  function automatic logic [7:0] op_byte(input logic [31:0] v, input int n, input int k);
    return v[8*(n-1-k) +: 8];
  endfunction

  task automatic xfer(input bit wr, input logic [1:0] siz, input logic [AW-1:0] a0,
                      input logic [31:0] wd, input bit wide, input int max_wait);
    int total = bytes_of(siz);
    int rem = total;
    int done_k = 0;
    int cycles = 0;
    logic [AW-1:0] a = a0;
    logic [31:0] exp_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_siz = siz; req_addr = a0; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      int n;
      int w;
      chk(bus_strobe == 1'b1, "R3 strobe", 32'(bus_strobe), 32'd1);
      chk(bus_addr == a, "R3 addr", 32'(bus_addr), 32'(a));
      chk(bus_siz == code_of(rem), "R3 siz", 32'(bus_siz), 32'(code_of(rem)));
      chk(bus_write == wr, "R4 dir", 32'(bus_write), 32'(wr));
      if (wr) begin
        logic [15:0] ew;
        ew[15:8] = op_byte(wd, total, done_k);
        ew[7:0]  = (rem == 1) ? op_byte(wd, total, done_k) : op_byte(wd, total, done_k + 1);
        chk(bus_wdata == ew, "R7 wdata", 32'(bus_wdata), 32'(ew));
      end
      w = (max_wait > 0) ? int'($urandom_range(max_wait, 0)) : 0;
      for (int i = 0; i < w; i++) begin
        @(negedge clk);
        chk(bus_strobe && bus_addr == a && bus_siz == code_of(rem), "R4 hold",
            {bus_strobe, 7'd0, bus_addr}, {1'b1, 7'd0, a});
      end
      n = (wide && !a[0] && rem >= 2) ? 2 : 1;
      if (!wr) begin
        if (n == 2) bus_rdata = {mem_b(a), mem_b(a + 1)};
        else if (wide && a[0]) bus_rdata = {8'($urandom), mem_b(a)};
        else bus_rdata = {mem_b(a), 8'($urandom)};
        for (int k = 0; k < n; k++) exp_rd = {exp_rd[23:0], mem_b(a + AW'(k))};
      end
      ack_word = wide;
      ack_byte = ~wide | ($urandom_range(1, 0) == 1);  // R5: both asserted still means wide
      @(negedge clk);
      ack_word = 1'b0; ack_byte = 1'b0; bus_rdata = 16'($urandom);
      cycles++;
      rem -= n; done_k += n; a += AW'(n);
      if (rem == 0) break;
      chk(bus_strobe == 1'b0, "R6 gap", 32'(bus_strobe), 32'd0);
      chk(done == 1'b0, "R9 early done", 32'(done), 32'd0);
      @(negedge clk);
    end
    chk(done == 1'b1, "R9 done", 32'(done), 32'd1);
    chk(bus_strobe == 1'b0, "R9 strobe idle", 32'(bus_strobe), 32'd0);
    if (!wr) chk(rdata == exp_rd, "R8 rdata", rdata, exp_rd);
    begin
      int ec = (!wide) ? total : ((total == 1) ? 1 : total / 2);
      chk(cycles == ec, "R10 cycle count", 32'(cycles), 32'(ec));
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 pulse", 32'(done), 32'd0);
  endtask

  task automatic bad_req(input logic [1:0] siz, input logic [AW-1:0] a0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_siz = siz; req_addr = a0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err == 1'b1, "R2 err", 32'(req_err), 32'd1);
    chk(bus_strobe == 1'b0 && req_ready == 1'b1, "R2 no start",
        {bus_strobe, req_ready}, 32'b01);
    @(negedge clk);
    chk(req_err == 1'b0, "R2 err pulse", 32'(req_err), 32'd0);
    chk(bus_strobe == 1'b0, "R2 stays idle", 32'(bus_strobe), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(bus_strobe == 1'b0 && done == 1'b0 && req_err == 1'b0, "R1 quiet",
        {bus_strobe, done, req_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && bus_strobe == 1'b0, "R1 after release",
        {req_ready, bus_strobe}, 32'b10);

    // directed R10 / R5 corners
    xfer(1'b0, 2'b00, 24'h001000, 32'h0, 1'b0, 0);       // long to 8-bit: 4 cycles
    xfer(1'b0, 2'b00, 24'h001010, 32'h0, 1'b1, 0);       // long to 16-bit: 2 cycles
    xfer(1'b0, 2'b10, 24'h002002, 32'h0, 1'b1, 3);       // word to 16-bit: 1 cycle
    xfer(1'b0, 2'b10, 24'h002004, 32'h0, 1'b0, 2);       // word to 8-bit: 2 cycles
    xfer(1'b0, 2'b01, 24'h003001, 32'h0, 1'b1, 0);       // R8 odd byte on low lane
    xfer(1'b0, 2'b01, 24'h003002, 32'h0, 1'b1, 0);       // R8 even byte on high lane
    xfer(1'b1, 2'b00, 24'h004000, 32'hA1B2C3D4, 1'b0, 4); // R7 long write, 8-bit
    xfer(1'b1, 2'b00, 24'h004100, 32'h11223344, 1'b1, 1); // R7 long write, 16-bit
    xfer(1'b1, 2'b01, 24'h004203, 32'h000000E7, 1'b1, 0); // R7 byte duplicated
    // R2 refusals
    bad_req(2'b10, 24'h005001);
    bad_req(2'b00, 24'h005003);
    bad_req(2'b11, 24'h005000);

    // constrained random
    for (int t = 0; t < 80; t++) begin
      logic [1:0] s;
      logic [AW-1:0] a;
      int pick = int'($urandom_range(2, 0));
      s = (pick == 0) ? 2'b01 : (pick == 1) ? 2'b10 : 2'b00;
      a = AW'($urandom);
      if (s != 2'b01) a[0] = 1'b0;
      xfer($urandom_range(1, 0) == 1, s, a, $urandom, $urandom_range(1, 0) == 1,
           int'($urandom_range(3, 0)));
      if (t % 20 == 7) bad_req(2'b00, a | AW'(1));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule